// File: doc/BRIEF.md
# Link State History Failure Classifier

This block watches the 8-bit training state code of one link port and keeps a short, change-only record of the states it has passed through. A code is written into the record only when it differs from the newest stored entry, so a port that sits in one state for thousands of cycles takes up a single slot. Slot 0 always holds the newest code.

When a supervisor sees that a port has not reached the active state within its time budget, it raises a classify request. The block then scans the record in one combinational pass and, one cycle later, returns a 2-bit verdict with a valid strobe. The verdict tells the supervisor whether to treat the port as being in compliance, as having a broken lane, as failing at the higher speed, or as a plain training failure.

Two live status flags are always driven from the newest entry. One shows that the active state has been reached and one shows that a receiver is present. A clear input wipes the record before a new training attempt.

Top module: `lsh_classifier`

## Requirements
- R1: While reset is low, and one cycle after `clear_i`, every history slot holds the reserved empty code 0xFF. In this state `valid_o`, `l0_o` and `rx_detect_o` are 0, and a classify returns verdict 0.
- R2: On a clock edge where `clear_i` is low and `code_i` differs from slot 0, the history shifts by one toward older slots and `code_i` enters slot 0. A code equal to slot 0 leaves the history unchanged, so repeated codes never make duplicate adjacent entries.
- R3: The history holds 16 entries. A push moves the entry in slot 15 out, and that entry then no longer takes part in any match.
- R4: Each cycle in which `classify_i` is high makes `valid_o` high for exactly one cycle on the next cycle. `valid_o` is low in every other cycle.
- R5: If slot 0 holds 0x07, the verdict is 1 (compliance). This check has priority over every other check.
- R6: If, for some k, slot k holds 0x2A and slot k+1 holds 0x06, the verdict is 2 (broken lane). The reversed order, with 0x06 in slot k and 0x2A in slot k+1, does not match.
- R7: If R5 and R6 do not apply, and for some k slot k holds 0x2A and slot k+1 holds 0x09 or 0x0B, the verdict is 3 (speed failure).
- R8: If none of R5 to R7 applies, the verdict is 0 (training failure).
- R9: `l0_o` is 1 exactly when slot 0 holds 0x10.
- R10: `rx_detect_o` is 1 exactly when slot 0 holds a code above 0x04 that is not the empty code 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Fill the history with the empty code |
| code_i | input | 8 | Current link training state code, sampled on every edge |
| classify_i | input | 1 | Request a verdict on the stored history |
| valid_o | output | 1 | The verdict is valid in this cycle |
| verdict_o | output | 2 | 0 fail, 1 compliance, 2 broken lane, 3 speed failure |
| l0_o | output | 1 | The newest state is the active state |
| rx_detect_o | output | 1 | The newest state shows that a receiver is present |

## Verification
The assertions assume that 0xFF is never a real state code. When `clear_i` is low, a 0xFF on `code_i` would be stored like any other code and would break the rule that the empty code never takes part in a match. The push and hold properties also assume that `code_i` is stable in each cycle. The stimulus puts 0xFF on `code_i` only together with `clear_i`, and after each push it holds the last code steady so that no extra push happens. All real codes in the stimulus are drawn from values below 0x40.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  localparam int unsigned CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_EMPTY   = 8'hFF;
  localparam logic [CODE_W-1:0] CODE_L0      = 8'h10;
  localparam logic [CODE_W-1:0] CODE_COMPLY  = 8'h07;
  localparam logic [CODE_W-1:0] CODE_RECOV   = 8'h2A;
  localparam logic [CODE_W-1:0] CODE_LANE    = 8'h06;
  localparam logic [CODE_W-1:0] CODE_SPD_A   = 8'h09;
  localparam logic [CODE_W-1:0] CODE_SPD_B   = 8'h0B;
  localparam logic [CODE_W-1:0] CODE_RX_MAX  = 8'h04;

  typedef enum logic [1:0] {
    VERD_FAIL   = 2'd0,
    VERD_COMPLY = 2'd1,
    VERD_BROKEN = 2'd2,
    VERD_SPEED  = 2'd3
  } verdict_e;
endpackage

// File: rtl/lsh_history.sv
module lsh_history
  import lsh_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clear_i,
  input  logic [CODE_W-1:0]             code_i,
  output logic [DEPTH-1:0][CODE_W-1:0]  hist_o
);
  logic [DEPTH-1:0][CODE_W-1:0] hist_q;
  logic                         push;

  assign push   = !clear_i && (code_i != hist_q[0]);
  assign hist_o = hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= {DEPTH{CODE_EMPTY}};
    end else if (clear_i) begin
      hist_q <= {DEPTH{CODE_EMPTY}};
    end else if (push) begin
      hist_q <= {hist_q[DEPTH-2:0], code_i};
    end
  end

  // R1: a clear leaves the newest and oldest slots empty
  a_r1_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (hist_q[0] == CODE_EMPTY) && (hist_q[DEPTH-1] == CODE_EMPTY));

  // R2: a changed code enters slot 0 and the old newest moves to slot 1
  a_r2_push_shifts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && code_i != hist_q[0]) |=>
      (hist_q[0] == $past(code_i)) && (hist_q[1] == $past(hist_q[0])) && (hist_q[0] != hist_q[1]));

  // R2: a repeated code leaves the history untouched
  a_r2_repeat_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && code_i == hist_q[0]) |=> $stable(hist_q));
endmodule

// File: rtl/lsh_pair_scan.sv
module lsh_pair_scan
  import lsh_pkg::*;
#(
  parameter int unsigned       DEPTH  = 16,
  parameter logic [CODE_W-1:0] NEWER  = CODE_RECOV,
  parameter logic [CODE_W-1:0] OLDER  = CODE_LANE
) (
  input  logic [DEPTH-1:0][CODE_W-1:0] hist_i,
  output logic                         hit_o
);
  localparam int unsigned NPAIR = DEPTH - 1;
  logic [NPAIR-1:0] pair_hit;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign pair_hit[k] = (hist_i[k] == NEWER) && (hist_i[k+1] == OLDER);
  end

  assign hit_o = |pair_hit;
endmodule

// File: rtl/lsh_classifier.sv
module lsh_classifier
  import lsh_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              classify_i,
  output logic              valid_o,
  output logic [1:0]        verdict_o,
  output logic              l0_o,
  output logic              rx_detect_o
);
  logic [DEPTH-1:0][CODE_W-1:0] hist;
  logic [CODE_W-1:0]            newest;
  logic                         hit_lane, hit_spd_a, hit_spd_b;
  verdict_e                     verdict_d, verdict_q;
  logic                         valid_q;

  lsh_history #(.DEPTH(DEPTH)) i_history (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .code_i  (code_i),
    .hist_o  (hist)
  );

  lsh_pair_scan #(.DEPTH(DEPTH), .NEWER(CODE_RECOV), .OLDER(CODE_LANE)) i_scan_lane (
    .hist_i (hist), .hit_o (hit_lane)
  );
  lsh_pair_scan #(.DEPTH(DEPTH), .NEWER(CODE_RECOV), .OLDER(CODE_SPD_A)) i_scan_spd_a (
    .hist_i (hist), .hit_o (hit_spd_a)
  );
  lsh_pair_scan #(.DEPTH(DEPTH), .NEWER(CODE_RECOV), .OLDER(CODE_SPD_B)) i_scan_spd_b (
    .hist_i (hist), .hit_o (hit_spd_b)
  );

  assign newest = hist[0];

  always_comb begin
    if (newest == CODE_COMPLY)          verdict_d = VERD_COMPLY;
    else if (hit_lane)                  verdict_d = VERD_BROKEN;
    else if (hit_spd_a || hit_spd_b)    verdict_d = VERD_SPEED;
    else                                verdict_d = VERD_FAIL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      verdict_q <= VERD_FAIL;
    end else begin
      valid_q <= classify_i;
      if (classify_i) verdict_q <= verdict_d;
    end
  end

  assign valid_o     = valid_q;
  assign verdict_o   = verdict_q;
  assign l0_o        = (newest == CODE_L0);
  assign rx_detect_o = (newest > CODE_RX_MAX) && (newest != CODE_EMPTY);

  // R4: one strobe per request cycle, none otherwise
  a_r4_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    classify_i |=> valid_o);
  a_r4_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !classify_i |=> !valid_o);

  // R5: compliance wins over every pair match
  a_r5_comply_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (classify_i && newest == CODE_COMPLY) |=> (verdict_o == 2'd1));

  // R6: a lane-pair hit without compliance gives broken lane
  a_r6_lane_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (classify_i && newest != CODE_COMPLY && hit_lane) |=> (verdict_o == 2'd2));
endmodule

// File: tb/test_lsh_classifier.sv
`timescale 1ns/1ps
module test_lsh_classifier;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic [7:0] code_i = 8'hFF;
  logic       classify_i = 1'b0;
  logic       valid_o, l0_o, rx_detect_o;
  logic [1:0] verdict_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  lsh_classifier i_lsh_classifier (
    .clk_i, .rst_ni, .clear_i, .code_i, .classify_i,
    .valid_o, .verdict_o, .l0_o, .rx_detect_o
  );

  // four codes pushed oldest first (FF = skip), then expected verdict
  localparam int NVEC = 8;
  localparam logic [33:0] VEC_TBL [NVEC] = '{
    {8'h01, 8'h02, 8'h03, 8'h04, 2'd0},  // R8 no pattern
    {8'h03, 8'h06, 8'h2A, 8'h05, 2'd2},  // R6 lane pair mid-history
    {8'h09, 8'h2A, 8'hFF, 8'hFF, 2'd3},  // R7 first speed pair
    {8'h0B, 8'h2A, 8'h03, 8'hFF, 2'd3},  // R7 second speed pair
    {8'h06, 8'h2A, 8'h07, 8'hFF, 2'd1},  // R5 compliance over lane pair
    {8'h2A, 8'h06, 8'hFF, 8'hFF, 2'd0},  // R6 reversed order no match
    {8'h06, 8'h2A, 8'h09, 8'h2A, 2'd2},  // R6 lane beats speed pair
    {8'h07, 8'h05, 8'hFF, 8'hFF, 2'd0}   // R5 only newest counts
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    code_i  = 8'hFF;
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] c);
    code_i = c;
    @(negedge clk_i);
  endtask

  task automatic classify(input string req, input int exp);
    classify_i = 1'b1;
    @(negedge clk_i);
    classify_i = 1'b0;
    check({req, " valid"}, int'(valid_o), 1);
    check({req, " verdict"}, int'(verdict_o), exp);
    @(negedge clk_i);
    check("R4 single strobe", int'(valid_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", int'(valid_o), 0);
    check("R1 reset l0", int'(l0_o), 0);
    check("R1 reset rx", int'(rx_detect_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    classify("R1 empty", 0);

    for (int v = 0; v < NVEC; v++) begin
      do_clear();
      for (int j = 0; j < 4; j++) begin
        logic [7:0] c;
        c = VEC_TBL[v][33 - 8*j -: 8];
        if (c != 8'hFF) push(c);
      end
      classify($sformatf("R5-8 vec%0d", v), int'(VEC_TBL[v][1:0]));
    end

    // R2 repeats do not split a pair
    do_clear();
    push(8'h06); push(8'h06); push(8'h06); push(8'h2A); push(8'h2A);
    classify("R2 change-only", 2);

    // R3 depth edge: pair still in slots 14/15
    do_clear();
    push(8'h06); push(8'h2A);
    for (int i = 0; i < 14; i++) push(8'h30 + 8'(i));
    classify("R3 pair at oldest", 2);
    push(8'h3F);
    classify("R3 pair shifted out", 0);

    // R1 clear wipes a match
    do_clear();
    classify("R1 after clear", 0);
    check("R1 clear l0", int'(l0_o), 0);

    // R4 back-to-back requests
    push(8'h07);
    classify_i = 1'b1;
    @(negedge clk_i);
    check("R4 b2b first", int'(valid_o), 1);
    @(negedge clk_i);
    classify_i = 1'b0;
    check("R4 b2b second", int'(valid_o), 1);
    check("R5 b2b verdict", int'(verdict_o), 1);
    @(negedge clk_i);
    check("R4 b2b end", int'(valid_o), 0);

    // R9 / R10 live status
    push(8'h10);
    check("R9 l0 set", int'(l0_o), 1);
    check("R10 rx on l0", int'(rx_detect_o), 1);
    push(8'h04);
    check("R9 l0 clear", int'(l0_o), 0);
    check("R10 rx at 4", int'(rx_detect_o), 0);
    push(8'h05);
    check("R10 rx at 5", int'(rx_detect_o), 1);
    do_clear();
    check("R10 rx empty", int'(rx_detect_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
      $finish;
    end
  end
endmodule